// File: doc/BRIEF.md
# Flash Erase Strategy Sequencer

This block clears the main flash of a target microcontroller before a new image is written into it. On a start pulse it captures the image base address, the image length in bytes, a page-size code and two capability flags. From these it picks a plan: whole-array erase of the low half, high-half erase followed by low-half erase, or erase page by page across the image range. It then carries out that plan as single word transactions on a simple register-access port. That port has request, write-enable, address, write data, read data and acknowledge signals, and each transaction ends when acknowledge is high at a clock edge.

After each erase command the block reads the target's status register until the busy flag clears. If the flag is still set after a fixed number of reads, the block gives up. When the target can write two words at once, the block first turns on that mode in the target's write-control register. The block ends every run with a one-cycle completion pulse, and the error flag is high in the same cycle when the run timed out.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the block makes no request and holds `done` and `err` low until a start pulse is accepted.
- R2: When `dual_word` is 1 at start, the first transaction writes value 1 (bit 0 = double-word enable) to register `CTRL_BASE+8`. When it is 0, no such write takes place.
- R3: When `img_base` is non-zero or `has_mass` is 0, the block runs in page mode. For each page address p, starting at `img_base` and stepping by the page size while p < `img_base+img_len`, it writes p to `CTRL_BASE+16` and then writes command value 1 (page erase) to `CTRL_BASE+12`.
- R4: The page size is 512 bytes shifted left by `page_sel` (0 gives 512, 1 gives 1024, 2 gives 2048, 3 gives 4096).
- R5: In mass mode (base zero and mass erase supported), when `img_len` is at most `HALF_BYTES`, the block writes only the low-half command, value 4, to `CTRL_BASE+12`.
- R6: In mass mode, when `img_len` exceeds `HALF_BYTES`, the block writes the high-half command (value 8), waits for it to complete, then writes the low-half command (value 4).
- R7: After every command write, the block reads `CTRL_BASE+28` until bit 0 (busy) reads 0. It issues no further write before that read, and it keeps each request's address, data and direction steady until acknowledge.
- R8: If `POLL_LIMIT` status reads in a row all return busy, the block issues nothing more and ends with `done` and `err` both high.
- R9: A run that finishes without a timeout ends with a single-cycle `done` pulse and `err` low. No request is active in that cycle.
- R10: A start pulse that arrives while a run is in progress is ignored, and the running sequence is unchanged.
- R11: In page mode with `img_len` of 0, the block erases no page and goes straight to `done`, after the optional write from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; ignored while a run is active |
| img_base | input | AW | Image start address in target flash |
| img_len | input | AW | Image length in bytes |
| page_sel | input | 2 | Page size code, 512 << code bytes |
| has_mass | input | 1 | Target supports half-array mass erase |
| dual_word | input | 1 | Target is a large-flash part with double-word write |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with acknowledge |
| bus_ack | input | 1 | Transaction complete |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Status poll timed out, valid with done |

## Verification
The bench builds the block with `HALF_BYTES` set to 4096 and `POLL_LIMIT` set to 4 instead of 512 KB and 400. This makes the two-step high/low mass erase reachable with images of a few kilobytes and keeps every page sweep down to a handful of pages. The small poll limit lets the bench hit both sides of the timeout edge exactly: three busy reads followed by a clear read, and four busy reads in a row. Its register model acknowledges every request and returns a scripted number of busy reads after each command. Every transaction is logged and compared entry by entry against a sequence the bench builds from the requirements.

// File: rtl/erase_pkg.sv
package erase_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_DBL,
        S_PADDR,
        S_CMD,
        S_POLL
    } seq_st_e;

    localparam int unsigned OFS_WRCTL = 8;
    localparam int unsigned OFS_CMD   = 12;
    localparam int unsigned OFS_ADDR  = 16;
    localparam int unsigned OFS_STAT  = 28;

    localparam int unsigned CMD_PAGE  = 1;
    localparam int unsigned CMD_LOWER = 4;
    localparam int unsigned CMD_UPPER = 8;
    localparam int unsigned WR_DOUBLE = 1;
    localparam int unsigned BUSY_BIT  = 0;
endpackage

// File: rtl/erase_plan.sv
module erase_plan #(
    parameter int unsigned AW         = 32,
    parameter int unsigned HALF_BYTES = 524288,
    parameter int unsigned MIN_PAGE   = 512
) (
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] len_i,
    input  logic [1:0]    sel_i,
    input  logic          mass_ok_i,
    output logic          page_mode_o,
    output logic          big_o,
    output logic          empty_o,
    output logic [AW-1:0] page_bytes_o,
    output logic [AW-1:0] end_o
);
    localparam logic [AW-1:0] HALF_W = AW'(HALF_BYTES);
    localparam logic [AW-1:0] MIN_W  = AW'(MIN_PAGE);

    always_comb begin
        page_mode_o  = (base_i != '0) || !mass_ok_i;
        big_o        = len_i > HALF_W;
        empty_o      = len_i == '0;
        page_bytes_o = MIN_W << sel_i;
        end_o        = base_i + len_i;
    end
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
    parameter int unsigned LIMIT = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic bump_i,
    output logic last_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)       cnt_d = '0;
        else if (bump_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = cnt_q == LAST_V;
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import erase_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned DW         = 32,
    parameter logic [31:0] CTRL_BASE  = 32'h4001_0000,
    parameter int unsigned HALF_BYTES = 524288,
    parameter int unsigned POLL_LIMIT = 400,
    parameter int unsigned MIN_PAGE   = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] img_base,
    input  logic [AW-1:0] img_len,
    input  logic [1:0]    page_sel,
    input  logic          has_mass,
    input  logic          dual_word,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    output logic          done,
    output logic          err
);
    localparam logic [AW-1:0] BASE_W = AW'(CTRL_BASE);

    typedef struct packed {
        seq_st_e       st;
        logic          page_mode;
        logic          big;
        logic          empty;
        logic          lower_next;
        logic [AW-1:0] cur;
        logic [AW-1:0] pg;
        logic [AW-1:0] stop_a;
        logic [DW-1:0] cmd;
        logic          done;
        logic          err;
    } seq_t;

    seq_t q, d;

    logic          pl_page, pl_big, pl_empty;
    logic [AW-1:0] pl_pg, pl_end;
    logic          tmr_last;
    logic          tmr_clr, tmr_bump;
    logic          busy_seen;

    erase_plan #(.AW(AW), .HALF_BYTES(HALF_BYTES), .MIN_PAGE(MIN_PAGE)) plan_i (
        .base_i      (img_base),
        .len_i       (img_len),
        .sel_i       (page_sel),
        .mass_ok_i   (has_mass),
        .page_mode_o (pl_page),
        .big_o       (pl_big),
        .empty_o     (pl_empty),
        .page_bytes_o(pl_pg),
        .end_o       (pl_end)
    );

    assign busy_seen = bus_rdata[BUSY_BIT];
    assign tmr_clr   = (q.st == S_CMD) && bus_ack;
    assign tmr_bump  = (q.st == S_POLL) && bus_ack && busy_seen;

    poll_timer #(.LIMIT(POLL_LIMIT)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .bump_i(tmr_bump),
        .last_o(tmr_last)
    );

    // request outputs decoded from registered state
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = BASE_W;
        bus_wdata = '0;
        unique case (q.st)
            S_DBL: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr = BASE_W + AW'(OFS_WRCTL); bus_wdata = DW'(WR_DOUBLE);
            end
            S_PADDR: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr = BASE_W + AW'(OFS_ADDR); bus_wdata = DW'(q.cur);
            end
            S_CMD: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr = BASE_W + AW'(OFS_CMD); bus_wdata = q.cmd;
            end
            S_POLL: begin
                bus_req = 1'b1;
                bus_addr = BASE_W + AW'(OFS_STAT);
            end
            default: ;
        endcase
    end

    always_comb begin
        logic          go, adv, fin;
        logic [AW-1:0] nxt;
        d    = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        go   = 1'b0;
        adv  = 1'b0;
        fin  = 1'b0;
        nxt  = q.cur + q.pg;
        unique case (q.st)
            S_IDLE: if (start) begin
                d.page_mode  = pl_page;
                d.big        = pl_big;
                d.empty      = pl_empty;
                d.pg         = pl_pg;
                d.stop_a     = pl_end;
                d.cur        = img_base;
                d.lower_next = 1'b0;
                if (dual_word) d.st = S_DBL;
                else           go   = 1'b1;
            end
            S_DBL:   if (bus_ack) go = 1'b1;
            S_PADDR: if (bus_ack) begin
                d.cmd = DW'(CMD_PAGE);
                d.st  = S_CMD;
            end
            S_CMD:   if (bus_ack) d.st = S_POLL;
            S_POLL:  if (bus_ack) begin
                if (!busy_seen) adv = 1'b1;
                else if (tmr_last) begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                    d.err  = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (adv) begin
            if (q.page_mode) begin
                if (nxt < q.stop_a) begin
                    d.cur = nxt;
                    d.st  = S_PADDR;
                end else fin = 1'b1;
            end else if (q.lower_next) begin
                d.lower_next = 1'b0;
                d.cmd        = DW'(CMD_LOWER);
                d.st         = S_CMD;
            end else fin = 1'b1;
        end

        if (go) begin
            if (d.page_mode) begin
                if (d.empty) fin = 1'b1;
                else         d.st = S_PADDR;
            end else if (d.big) begin
                d.cmd        = DW'(CMD_UPPER);
                d.lower_next = 1'b1;
                d.st         = S_CMD;
            end else begin
                d.cmd = DW'(CMD_LOWER);
                d.st  = S_CMD;
            end
        end

        if (fin) begin
            d.st   = S_IDLE;
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign err  = q.err;
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
    parameter int unsigned AW        = 32,
    parameter int unsigned DW        = 32,
    parameter logic [31:0] CTRL_BASE = 32'h4001_0000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_ack,
    input logic          done,
    input logic          err
);
    localparam logic [AW-1:0] CMD_A = AW'(CTRL_BASE) + AW'(12);

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr)
                                && $stable(bus_wdata) && $stable(bus_we));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_no_req_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    p_cmd_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && (bus_addr == CMD_A)
        |-> (bus_wdata == DW'(1)) || (bus_wdata == DW'(4)) || (bus_wdata == DW'(8)));
endmodule

bind flash_erase_seq flash_erase_seq_chk #(.AW(AW), .DW(DW), .CTRL_BASE(CTRL_BASE)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_ack  (bus_ack),
    .done     (done),
    .err      (err)
);

// File: tb/flash_erase_seq_tb_top.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;
    localparam int unsigned AW = 32;
    localparam int unsigned DW = 32;
    localparam logic [31:0] CB = 32'h4001_0000;
    localparam int unsigned HALF = 4096;
    localparam int unsigned LIM  = 4;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] len;
        logic [1:0]  sel;
        logic        mass;
        logic        dual;
        logic [7:0]  busy;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0,    32'd1000, 2'd0, 1'b1, 1'b0, 8'd1},  // R5 low only
        '{32'h0,    32'd5000, 2'd1, 1'b1, 1'b1, 8'd2},  // R2 R6 high then low
        '{32'h800,  32'd1024, 2'd0, 1'b1, 1'b0, 8'd0},  // R3 base non-zero
        '{32'h0,    32'd1500, 2'd1, 1'b0, 1'b1, 8'd3},  // R3 R4 no mass, 3 busy
        '{32'h1000, 32'd4096, 2'd3, 1'b1, 1'b0, 8'd0},  // R4 exact one page
        '{32'h2000, 32'd0,    2'd2, 1'b0, 1'b1, 8'd0},  // R11 empty
        '{32'h0,    32'd4096, 2'd2, 1'b1, 1'b0, 8'd0},  // R5 boundary len==HALF
        '{32'h0,    32'd100,  2'd0, 1'b1, 1'b0, 8'd4},  // R8 timeout mass
        '{32'h400,  32'd2048, 2'd0, 1'b1, 1'b0, 8'd9}   // R8 timeout page
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] img_base = '0, img_len = '0;
    logic [1:0]    page_sel = '0;
    logic          has_mass = 1'b0, dual_word = 1'b0;
    logic          bus_req, bus_we, done, err;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ack = 1'b0;

    always #10 clk = ~clk;

    flash_erase_seq #(.AW(AW), .DW(DW), .CTRL_BASE(CB),
                      .HALF_BYTES(HALF), .POLL_LIMIT(LIM)) dut_i (.*);

    int n_chk = 0, n_bad = 0;
    int run_id = 0, seen_id = 0;
    int cur_busy = 0, busy_left = 0;
    int log_n = 0;
    logic        log_we [64];
    logic [31:0] log_a  [64];
    logic [31:0] log_d  [64];
    int exp_n = 0;
    logic        exp_we [64];
    logic [31:0] exp_a  [64];
    logic [31:0] exp_d  [64];
    logic        exp_err;

    // register model: ack one negedge after a request, busy for a scripted count
    always @(negedge clk) begin
        if (seen_id != run_id) begin
            seen_id = run_id;
            log_n = 0;
            busy_left = 0;
        end
        if (bus_ack) bus_ack = 1'b0;
        else if (rst_n && bus_req) begin
            bus_ack = 1'b1;
            if (bus_we) begin
                bus_rdata = '0;
                if (bus_addr == CB + 12) busy_left = cur_busy;
                if (log_n < 64) begin
                    log_we[log_n] = 1'b1; log_a[log_n] = bus_addr; log_d[log_n] = bus_wdata;
                end
            end else begin
                bus_rdata = {31'd0, busy_left != 0};
                if (busy_left != 0) busy_left--;
                if (log_n < 64) begin
                    log_we[log_n] = 1'b0; log_a[log_n] = bus_addr; log_d[log_n] = bus_rdata;
                end
            end
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic push(input logic we, input logic [31:0] a, input logic [31:0] dt);
        exp_we[exp_n] = we; exp_a[exp_n] = a; exp_d[exp_n] = dt; exp_n++;
    endtask

    task automatic cmd_poll(input logic [31:0] cmd, input int busy, inout bit stop);
        int nr;
        push(1'b1, CB + 12, cmd);
        nr = (busy >= LIM) ? LIM : busy + 1;
        for (int i = 0; i < nr; i++) push(1'b0, CB + 28, (i < busy) ? 32'd1 : 32'd0);
        if (busy >= LIM) begin stop = 1'b1; exp_err = 1'b1; end
    endtask

    task automatic build_exp(input vec_t v);
        bit stop = 1'b0;
        logic [31:0] pg;
        exp_n = 0; exp_err = 1'b0;
        if (v.dual) push(1'b1, CB + 8, 32'd1);                  // R2
        if (v.base != 0 || !v.mass) begin                       // R3
            pg = 32'd512 << v.sel;                              // R4
            for (logic [31:0] a = v.base; a < v.base + v.len && !stop; a += pg) begin
                push(1'b1, CB + 16, a);
                cmd_poll(32'd1, v.busy, stop);
            end
        end else if (v.len > HALF) begin                        // R6
            cmd_poll(32'd8, v.busy, stop);
            if (!stop) cmd_poll(32'd4, v.busy, stop);
        end else cmd_poll(32'd4, v.busy, stop);                 // R5
    endtask

    task automatic launch(input vec_t v);
        @(negedge clk);
        run_id++;
        cur_busy = v.busy;
        img_base = v.base; img_len = v.len; page_sel = v.sel;
        has_mass = v.mass; dual_word = v.dual;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen, output logic e);
        seen = 1'b0; e = 1'b0;
        for (int c = 0; c < 3000 && !seen; c++) begin
            if (done) begin seen = 1'b1; e = err; end
            else @(negedge clk);
        end
    endtask

    task automatic compare(input int idx, input string rq);
        chk(log_n == exp_n, rq, $sformatf("vec %0d transaction count", idx), 64'(log_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < log_n; i++)
            chk(log_we[i] == exp_we[i] && log_a[i] == exp_a[i] && log_d[i] == exp_d[i], rq,
                $sformatf("vec %0d txn %0d {we,addr,data}", idx, i),
                {31'd0, log_we[i], log_a[i]} ^ 64'(log_d[i]) << 0,
                {31'd0, exp_we[i], exp_a[i]} ^ 64'(exp_d[i]) << 0);
    endtask

    task automatic run_vec(input int idx, input vec_t v, input string rq);
        bit seen; logic e;
        build_exp(v);
        launch(v);
        wait_done(seen, e);
        chk(seen, "R9", $sformatf("vec %0d done seen", idx), 64'(seen), 64'd1);
        chk(e == exp_err, exp_err ? "R8" : "R9", $sformatf("vec %0d err", idx), 64'(e), 64'(exp_err));
        @(negedge clk);
        chk(!done, "R9", $sformatf("vec %0d done single cycle", idx), 64'(done), 64'd0);
        chk(!bus_req, "R8", $sformatf("vec %0d quiet after end", idx), 64'(bus_req), 64'd0);
        compare(idx, rq);
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !done && !err, "R1", "reset quiet", {bus_req, done, err}, 64'd0);
        repeat (3) @(negedge clk);
        chk(!bus_req && !done, "R1", "idle without start", {bus_req, done}, 64'd0);

        for (int i = 0; i < NV; i++) run_vec(i, VECS[i], "R3/R5/R6/R7");

        // R10: a second start mid-run does not disturb the sequence
        begin
            bit seen; logic e;
            vec_t v = VECS[3];
            build_exp(v);
            launch(v);
            repeat (5) @(negedge clk);
            img_base = 32'h300; img_len = 32'd9000; has_mass = 1'b1; dual_word = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done(seen, e);
            chk(seen && !e, "R10", "restart ignored done", {seen, e}, 64'd2);
            @(negedge clk);
            compare(100, "R10");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule